// File: doc/BRIEF.md
# Interrupt Coprocessor Exception Controller

This block is the small system coprocessor of a 32-bit pipelined core. It watches three external interrupt request lines, remembers each rising request until it is served, and, when the global enable and that source's mask bit allow it, tells the core to redirect fetch to a fixed handler vector at 0x00000800. At that moment it stores the resume PC (the core's next PC) in an exception-PC register and records which source was taken. An exception-return strobe sends fetch back to the stored PC and enables interrupts again.

The core reads and writes the coprocessor through two ports. A move-from strobe with a 5-bit register index returns a value on a read bus. A move-to strobe with an index and data updates the status register. The status register holds the global enable and the per-source masks. Because the handler can enable interrupts again through the status register, a new interrupt can be taken while one is already being served. The core's software saves state between these levels.

A three-state machine sequences the redirects. In ST_IDLE it accepts requests. ST_IDLE goes to ST_VECTOR when an interrupt is taken and to ST_RETURN when an exception return is accepted. ST_VECTOR goes back to ST_IDLE after one cycle, and so does ST_RETURN. In ST_VECTOR the block drives the handler vector. In ST_RETURN it drives the saved PC.

Top module: `irq_cop_unit`

## Requirements
- R1: After reset, no redirect is driven, and reads of register 12 (status), 13 (cause) and 14 (EPC) all return 0.
- R2: A rising edge on request line i sets a pending flag that stays set until source i is taken, even while that source is masked. The pending flag is served once it is unmasked.
- R3: A pending source i is taken only if status bit 0 (global enable) and status bit 8+i (mask of source i) are both 1.
- R4: If several eligible sources are pending, the lowest-numbered source is taken. Its index is stored in bits 1:0 of register 13.
- R5: An interrupt taken in cycle t makes `redirect` high with `redirect_pc` = 0x00000800 in cycle t+1 only. A request edge sampled at one clock edge is therefore taken in the cycle that follows.
- R6: When an interrupt is taken, register 14 loads the value on `pc_next` from the cycle in which it was taken.
- R7: Taking an interrupt clears status bit 0. An accepted exception return sets status bit 0.
- R8: An exception-return strobe in ST_IDLE makes `redirect` high with `redirect_pc` equal to register 14 for exactly the next cycle.
- R9: A move-to write changes only status bits 10:8 and 0. Other status bits always read 0. Writes to any index other than 12 have no effect.
- R10: The read bus is 0 when the move-from strobe is low or when the index is not 12, 13 or 14.
- R11: If the handler sets the enable bit again, a new interrupt is taken. It overwrites registers 13 and 14.
- R12: If an exception return and an eligible interrupt occur in the same idle cycle, the return is served first. No interrupt is taken and no return is accepted while a redirect is being driven. A deferred request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 3 | External interrupt request lines |
| pc_next | input | 32 | PC at which the interrupted program resumes |
| mfc0_en | input | 1 | Move-from (read) strobe |
| mfc0_idx | input | 5 | Register index for the read |
| mfc0_data | output | 32 | Read data |
| mtc0_en | input | 1 | Move-to (write) strobe |
| mtc0_idx | input | 5 | Register index for the write |
| mtc0_data | input | 32 | Write data |
| eret_en | input | 1 | Exception-return strobe |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect target |

## Verification
The assertions assume that every input is a known value whenever reset is released. They also assume that exception returns are issued only from ST_IDLE when a real return is intended. The bench drives all inputs 2 ns after a rising edge and holds them stable until the next edge. It issues returns only after the vector cycle has passed, except in the one test that checks that a return and an interrupt arriving together are served in order. The sweep covers every mask value with every request pattern, and for each case it computes the source that should win as the lowest set bit of the request pattern ANDed with the mask.

// File: rtl/irq_cop_pkg.sv
package irq_cop_pkg;
    localparam int XLEN       = 32;
    localparam int NSRC       = 3;
    localparam int REGIDX_W   = 5;
    localparam int IDX_STATUS = 12;
    localparam int IDX_CAUSE  = 13;
    localparam int IDX_EPC    = 14;
    localparam int MASK_LSB   = 8;
    localparam logic [XLEN-1:0] VECTOR_PC = 32'h0000_0800;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VECTOR = 2'd1,
        ST_RETURN = 2'd2
    } cop_state_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                pend[i] <= 1'b0;
            end else begin
                prev_q  <= req[i];
                pend[i] <= (pend[i] & ~clr[i]) | (req[i] & ~prev_q);
            end
        end

        // R2: a served flag drops unless a new edge arrives in the same cycle
        assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !(req[i] && !prev_q)) |=> !pend[i]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N    = 3,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    mask,
    input  logic            en,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] grant_idx,
    output logic            any
);
    logic [N-1:0] elig;
    assign elig = en ? (pend & mask) : '0;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDXW'(i);
                any       = 1'b1;
            end
        end
    end

    // R4: never more than one source granted
    always_comb begin
        if (!$isunknown(grant)) begin
            assert_one_grant_R4: assert ($onehot0(grant));
        end
    end
endmodule

// File: rtl/irq_cop_unit.sv
module irq_cop_unit
    import irq_cop_pkg::*;
#(
    parameter int W      = XLEN,
    parameter int NS     = NSRC,
    parameter int IW     = REGIDX_W,
    parameter int MLSB   = MASK_LSB,
    parameter logic [W-1:0] VEC = VECTOR_PC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] irq_req,
    input  logic [W-1:0]  pc_next,
    input  logic          mfc0_en,
    input  logic [IW-1:0] mfc0_idx,
    output logic [W-1:0]  mfc0_data,
    input  logic          mtc0_en,
    input  logic [IW-1:0] mtc0_idx,
    input  logic [W-1:0]  mtc0_data,
    input  logic          eret_en,
    output logic          redirect,
    output logic [W-1:0]  redirect_pc
);
    localparam int IDXW = (NS > 1) ? $clog2(NS) : 1;

    cop_state_e state_q, state_d;

    logic          status_en;
    logic [NS-1:0] status_mask;
    logic [IDXW-1:0] cause_q;
    logic [W-1:0]  epc_q;

    logic [NS-1:0]   pend, grant, clr;
    logic [IDXW-1:0] grant_idx;
    logic            any, idle, take, eret_go;

    irq_pend_latch #(.N(NS)) u_latch (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr), .pend(pend)
    );

    irq_prio_pick #(.N(NS), .IDXW(IDXW)) u_pick (
        .pend(pend), .mask(status_mask), .en(status_en),
        .grant(grant), .grant_idx(grant_idx), .any(any)
    );

    assign idle    = (state_q == ST_IDLE);
    assign eret_go = idle & eret_en;
    assign take    = idle & any & ~eret_en;
    assign clr     = take ? grant : '0;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eret_go)   state_d = ST_RETURN;
                else if (take) state_d = ST_VECTOR;
            end
            ST_VECTOR: state_d = ST_IDLE;
            ST_RETURN: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            unique case (state_d)
                ST_VECTOR: begin redirect <= 1'b1; redirect_pc <= VEC;   end
                ST_RETURN: begin redirect <= 1'b1; redirect_pc <= epc_q; end
                default:   begin redirect <= 1'b0; redirect_pc <= '0;    end
            endcase
        end
    end

    // status, cause and EPC registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_en   <= 1'b0;
            status_mask <= '0;
            cause_q     <= '0;
            epc_q       <= '0;
        end else begin
            if (mtc0_en && mtc0_idx == IW'(IDX_STATUS)) begin
                status_en   <= mtc0_data[0];
                status_mask <= mtc0_data[MLSB +: NS];
            end
            if (take) begin
                status_en <= 1'b0;
                cause_q   <= grant_idx;
                epc_q     <= pc_next;
            end else if (eret_go) begin
                status_en <= 1'b1;
            end
        end
    end

    // read port
    always_comb begin
        mfc0_data = '0;
        if (mfc0_en) begin
            if (mfc0_idx == IW'(IDX_STATUS)) begin
                mfc0_data[0]           = status_en;
                mfc0_data[MLSB +: NS]  = status_mask;
            end else if (mfc0_idx == IW'(IDX_CAUSE)) begin
                mfc0_data[IDXW-1:0]    = cause_q;
            end else if (mfc0_idx == IW'(IDX_EPC)) begin
                mfc0_data              = epc_q;
            end
        end
    end

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (redirect && redirect_pc == VEC));
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);
    assert_epc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc_q == $past(pc_next)));
    assert_en_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !status_en);
    assert_en_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eret_go |=> status_en);
    assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eret_go |=> (redirect && redirect_pc == epc_q));
    assert_no_take_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !take);
endmodule

// File: tb/sim_irq_cop_unit.sv
`timescale 1ns/1ps
module sim_irq_cop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_req = '0;
    logic [31:0] pc_next = '0;
    logic        mfc0_en = 1'b0;
    logic [4:0]  mfc0_idx = '0;
    logic [31:0] mfc0_data;
    logic        mtc0_en = 1'b0;
    logic [4:0]  mtc0_idx = '0;
    logic [31:0] mtc0_data = '0;
    logic        eret_en = 1'b0;
    logic        redirect;
    logic [31:0] redirect_pc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_cop_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pc_next(pc_next),
        .mfc0_en(mfc0_en), .mfc0_idx(mfc0_idx), .mfc0_data(mfc0_data),
        .mtc0_en(mtc0_en), .mtc0_idx(mtc0_idx), .mtc0_data(mtc0_data),
        .eret_en(eret_en), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        irq_req = '0; eret_en = 1'b0; mtc0_en = 1'b0; mfc0_en = 1'b0;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] v);
        mfc0_en = 1'b1; mfc0_idx = idx;
        #1 v = mfc0_data;
        mfc0_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        mtc0_en = 1'b1; mtc0_idx = idx; mtc0_data = d;
        tick();
        mtc0_en = 1'b0;
    endtask

    function automatic int lowest(input logic [2:0] v);
        for (int i = 0; i < 3; i++) if (v[i]) return i;
        return 0;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] epc_exp;
        do_reset();

        // R1 reset state
        chk("R1 redirect", {31'b0, redirect}, 32'd0);
        rd(5'd12, v); chk("R1 status", v, 32'd0);
        rd(5'd13, v); chk("R1 cause", v, 32'd0);
        rd(5'd14, v); chk("R1 epc", v, 32'd0);

        // R9 write masking and ignored indices
        wr(5'd12, 32'hFFFF_FFFF);
        rd(5'd12, v); chk("R9 status bits", v, 32'h0000_0701);
        wr(5'd13, 32'hFFFF_FFFF);
        wr(5'd14, 32'hFFFF_FFFF);
        rd(5'd13, v); chk("R9 cause untouched", v, 32'd0);
        rd(5'd14, v); chk("R9 epc untouched", v, 32'd0);
        // R10 read strobe low / unknown index
        mfc0_en = 1'b0; mfc0_idx = 5'd12; #1;
        chk("R10 strobe low", mfc0_data, 32'd0);
        rd(5'd5, v);  chk("R10 idx 5", v, 32'd0);
        rd(5'd15, v); chk("R10 idx 15", v, 32'd0);

        // R3 global enable off: no take
        do_reset();
        wr(5'd12, 32'h0000_0700);
        irq_req = 3'b001; tick(); irq_req = '0; tick();
        chk("R3 disabled no redirect", {31'b0, redirect}, 32'd0);
        tick();
        chk("R3 disabled still none", {31'b0, redirect}, 32'd0);

        // Sweep all masks and request patterns
        for (int m = 0; m < 8; m++) begin
            for (int p = 1; p < 8; p++) begin
                logic [2:0] el;
                int w;
                el = 3'(p) & 3'(m);
                do_reset();
                pc_next = 32'h0000_1000 + 32'(m * 64 + p * 4);
                wr(5'd12, (32'(m) << 8) | 32'd1);
                irq_req = 3'(p); tick(); irq_req = '0; tick();
                if (el != 0) begin
                    w = lowest(el);
                    chk("R5 redirect", {31'b0, redirect}, 32'd1);
                    chk("R5 vector", redirect_pc, 32'h0000_0800);
                    epc_exp = pc_next;
                    pc_next = 32'hDEAD_0000;
                    tick();
                    chk("R5 one cycle", {31'b0, redirect}, 32'd0);
                    rd(5'd13, v); chk("R4 cause", v, 32'(w));
                    rd(5'd14, v); chk("R6 epc", v, epc_exp);
                    rd(5'd12, v); chk("R7 en cleared", v, 32'(m) << 8);
                    eret_en = 1'b1; tick(); eret_en = 1'b0;
                    chk("R8 return redirect", {31'b0, redirect}, 32'd1);
                    chk("R8 return pc", redirect_pc, epc_exp);
                    rd(5'd12, v); chk("R7 en set", v, (32'(m) << 8) | 32'd1);
                    el[w] = 1'b0;
                    tick(); tick();
                    if (el != 0) begin
                        chk("R2 next pending taken", {31'b0, redirect}, 32'd1);
                        rd(5'd13, v); chk("R4 next cause", v, 32'(lowest(el)));
                    end else begin
                        chk("R2 nothing left", {31'b0, redirect}, 32'd0);
                    end
                end else begin
                    chk("R3 masked none", {31'b0, redirect}, 32'd0);
                    wr(5'd12, 32'h0000_0701);
                    tick();
                    chk("R2 sticky pending taken", {31'b0, redirect}, 32'd1);
                    rd(5'd13, v); chk("R2 sticky cause", v, 32'(lowest(3'(p))));
                end
            end
        end

        // R12 return and take in same cycle: return first
        do_reset();
        wr(5'd12, 32'h0000_0101);
        irq_req = 3'b001; tick(); irq_req = '0;
        eret_en = 1'b1; tick(); eret_en = 1'b0;
        chk("R12 return first", {31'b0, redirect}, 32'd1);
        chk("R12 return pc", redirect_pc, 32'd0);
        tick();
        chk("R12 idle gap", {31'b0, redirect}, 32'd0);
        tick();
        chk("R12 deferred take", redirect_pc, 32'h0000_0800);
        chk("R12 deferred redirect", {31'b0, redirect}, 32'd1);

        // R11 nested service
        do_reset();
        wr(5'd12, 32'h0000_0701);
        pc_next = 32'h0000_2000;
        irq_req = 3'b100; tick(); irq_req = '0; tick();
        chk("R11 first take", {31'b0, redirect}, 32'd1);
        wr(5'd12, 32'h0000_0701);
        pc_next = 32'h0000_0840;
        irq_req = 3'b001; tick(); irq_req = '0; tick();
        chk("R11 nested take", {31'b0, redirect}, 32'd1);
        rd(5'd14, v); chk("R11 epc overwritten", v, 32'h0000_0840);
        rd(5'd13, v); chk("R11 cause overwritten", v, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule